// File: doc/BRIEF.md
# Byte-Read Result FIFO with Fill Level

This block buffers 32-bit words produced by a flicker measurement engine, samples or results, until a host collects them. The host has only a byte-wide view. It selects one of four byte lanes of the oldest stored word with a two-bit lane number and a read strobe. The word is released only when the host moves from the last lane back to the first lane. The block reports how many words are waiting and keeps a sticky flag when a word had to be discarded because the store was full.

Default depth is 64 words, 256 bytes. The level output counts 0 (empty) through 64 (full) on 7 bits. Reading while nothing is stored is not an error: the byte returned is zero and no flag changes. A clear command discards everything.

Top module: `flk_byte_fifo`

## Requirements
- R1: After reset, `fill_level` is 0, `lost_flag` is 0 and `rd_byte` is 0x00.
- R2: Each accepted write raises `fill_level` by one, up to DEPTH (64). `fill_level` never exceeds DEPTH.
- R3: A read strobe with lane `rd_lane` returns byte `rd_lane` of the oldest word on `rd_byte` one cycle later. Lane 0 is bits 7:0 and lane 3 is bits 31:24.
- R4: A read of lane 0 that directly follows a read of lane 3, with no other read between them, removes the oldest word. That read returns lane 0 of the next word. No other read changes `fill_level`.
- R5: A read while `fill_level` is 0 returns 0x00 one cycle later. It changes neither `fill_level` nor `lost_flag`.
- R6: A write while `fill_level` equals DEPTH, in a cycle without a word removal, is dropped. Stored words stay unchanged and `lost_flag` becomes 1 in the next cycle.
- R7: `lost_flag` is sticky. It returns to 0 after any read strobe, unless a write is dropped in that same cycle.
- R8: A write and a word removal in the same cycle leave `fill_level` unchanged. This also holds when the store is full, and the write is then accepted.
- R9: `flush` empties the store and forces `fill_level` and `lost_flag` to 0 in the next cycle. It overrides writes and reads in the same cycle and cancels a pending lane-3 wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write one word this cycle |
| wr_word | input | 32 | Word to store |
| rd_strobe | input | 1 | Host byte read this cycle |
| rd_lane | input | 2 | Byte lane of the oldest word to read |
| flush | input | 1 | Discard all stored words |
| rd_byte | output | 8 | Byte returned one cycle after the strobe |
| fill_level | output | 7 | Words waiting, 0 to 64 |
| lost_flag | output | 1 | Sticky: a write was dropped while full |

## Verification
The bench builds the block with its default parameters: 32-bit words and 64 entries. At this size, filling the store to exactly 64 words and then pushing one more takes only a few hundred cycles. That brings the full-boundary drop, the overflow flag set and cleared, and a simultaneous write and removal at the full level within reach. The lane-wrap rule is exercised with non-wrapping lane orders, a lane 0 read without a preceding lane 3, and a wrap that empties the store.

// File: rtl/flk_fifo_pkg.sv
package flk_fifo_pkg;
  // byte count per stored word
  function automatic int unsigned lanes_of(input int unsigned word_w);
    return word_w / 8;
  endfunction
endpackage

// File: rtl/flk_fifo_ram.sv
module flk_fifo_ram #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/flk_fifo_ctrl.sv
module flk_fifo_ctrl #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          wr_valid,
  input  logic          rd_strobe,
  input  logic          pop_req,
  output logic          pop,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic          data_avail,
  output logic [LW-1:0] level,
  output logic          lost
);
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, empty, drop;

  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);
  assign pop   = pop_req && !empty && !flush;
  assign we    = wr_valid && !flush && (!full || pop);
  assign drop  = wr_valid && !flush && full && !pop;
  assign waddr = wr_ptr;
  // read address looks past the word being removed
  assign raddr = pop ? rd_ptr + AW'(1) : rd_ptr;
  assign data_avail = pop ? (level > LW'(1)) : !empty;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      lost   <= 1'b0;
    end else begin
      if (we)  wr_ptr <= wr_ptr + AW'(1);
      if (pop) rd_ptr <= rd_ptr + AW'(1);
      if (we && !pop)      level <= level + LW'(1);
      else if (pop && !we) level <= level - LW'(1);
      if (drop)           lost <= 1'b1;
      else if (rd_strobe) lost <= 1'b0;
    end
  end
endmodule

// File: rtl/flk_fifo_rdport.sv
module flk_fifo_rdport
  import flk_fifo_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned NL    = lanes_of(WORD_W),
  localparam int unsigned SW    = $clog2(NL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              rd_strobe,
  input  logic [SW-1:0]     rd_lane,
  input  logic              data_avail,
  input  logic [WORD_W-1:0] ram_word,
  output logic              pop_req,
  output logic [7:0]        rd_byte
);
  logic          armed;
  logic          valid_q;
  logic [SW-1:0] lane_q;
  logic [7:0]    lane_bytes [NL];

  assign pop_req = rd_strobe && (rd_lane == '0) && armed;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      armed   <= 1'b0;
      valid_q <= 1'b0;
      lane_q  <= '0;
    end else if (rd_strobe) begin
      armed   <= (rd_lane == SW'(NL - 1));
      valid_q <= data_avail;
      lane_q  <= rd_lane;
    end
  end

  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign lane_bytes[g] = ram_word[8*g +: 8];
  end

  assign rd_byte = valid_q ? lane_bytes[lane_q] : 8'h00;
endmodule

// File: rtl/flk_byte_fifo.sv
module flk_byte_fifo #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned LW    = $clog2(DEPTH + 1),
  localparam int unsigned SW    = $clog2(WORD_W / 8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_strobe,
  input  logic [SW-1:0]     rd_lane,
  input  logic              flush,
  output logic [7:0]        rd_byte,
  output logic [LW-1:0]     fill_level,
  output logic              lost_flag
);
  logic              pop_req, pop, we, data_avail;
  logic [AW-1:0]     waddr, raddr;
  logic [WORD_W-1:0] ram_word;

  flk_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .flush(flush), .wr_valid(wr_valid),
    .rd_strobe(rd_strobe), .pop_req(pop_req), .pop(pop), .we(we),
    .waddr(waddr), .raddr(raddr), .data_avail(data_avail),
    .level(fill_level), .lost(lost_flag)
  );

  flk_fifo_ram #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wr_word),
    .raddr(raddr), .rdata(ram_word)
  );

  flk_fifo_rdport #(.WORD_W(WORD_W)) u_rd (
    .clk(clk), .rst(rst), .flush(flush), .rd_strobe(rd_strobe),
    .rd_lane(rd_lane), .data_avail(data_avail), .ram_word(ram_word),
    .pop_req(pop_req), .rd_byte(rd_byte)
  );
endmodule

// File: rtl/flk_byte_fifo_chk.sv
module flk_byte_fifo_chk #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LW    = 7,
  parameter int unsigned SW    = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_valid,
  input logic          rd_strobe,
  input logic [SW-1:0] rd_lane,
  input logic          flush,
  input logic [7:0]    rd_byte,
  input logic [LW-1:0] fill_level,
  input logic          lost_flag
);
  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fill_level <= LW'(DEPTH));
  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (fill_level == '0) && !lost_flag);
  // R6
  drop_sets_lost_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !flush && !rd_strobe && fill_level == LW'(DEPTH)) |=> lost_flag);
  // R7
  read_clears_lost_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !wr_valid && !flush) |=> !lost_flag);
  // R5
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && fill_level == '0) |=> rd_byte == 8'h00);
  // R4
  no_pop_other_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (!flush && !wr_valid && (!rd_strobe || rd_lane != '0)) |=> fill_level == $past(fill_level));
  // R2
  write_no_shrink_chk: assert property (@(posedge clk) disable iff (rst)
    (!flush && !rd_strobe) |=> fill_level >= $past(fill_level));
endmodule

bind flk_byte_fifo flk_byte_fifo_chk #(.DEPTH(DEPTH), .LW(LW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .rd_strobe(rd_strobe),
  .rd_lane(rd_lane), .flush(flush), .rd_byte(rd_byte),
  .fill_level(fill_level), .lost_flag(lost_flag)
);

// File: tb/flk_byte_fifo_bench.sv
module flk_byte_fifo_bench;
  localparam int DEPTH = 64;
  // op: 0 write, 1 read and check byte, 2 check level
  localparam int NV = 15;
  localparam logic [43:0] VEC [NV] = '{
    {2'd0, 2'd0, 32'h44332211, 8'h00},
    {2'd0, 2'd0, 32'hDDCCBBAA, 8'h00},
    {2'd2, 2'd0, 32'h0,        8'd2 },
    {2'd1, 2'd0, 32'h0,        8'h11},
    {2'd1, 2'd1, 32'h0,        8'h22},
    {2'd1, 2'd2, 32'h0,        8'h33},
    {2'd1, 2'd3, 32'h0,        8'h44},
    {2'd2, 2'd0, 32'h0,        8'd2 },
    {2'd1, 2'd0, 32'h0,        8'hAA},
    {2'd2, 2'd0, 32'h0,        8'd1 },
    {2'd1, 2'd1, 32'h0,        8'hBB},
    {2'd1, 2'd0, 32'h0,        8'hAA},
    {2'd1, 2'd3, 32'h0,        8'hDD},
    {2'd1, 2'd0, 32'h0,        8'h00},
    {2'd2, 2'd0, 32'h0,        8'd0 }
  };

  logic        clk = 0, rst = 1;
  logic        wr_valid = 0, rd_strobe = 0, flush = 0;
  logic [31:0] wr_word = '0;
  logic [1:0]  rd_lane = '0;
  logic [7:0]  rd_byte;
  logic [6:0]  fill_level;
  logic        lost_flag;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  flk_byte_fifo u_flk_byte_fifo (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_word(wr_word),
    .rd_strobe(rd_strobe), .rd_lane(rd_lane), .flush(flush),
    .rd_byte(rd_byte), .fill_level(fill_level), .lost_flag(lost_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive for one edge, sample at the following falling edge
  task automatic cyc(input bit w, input logic [31:0] d, input bit r,
                     input logic [1:0] l, input bit f);
    @(negedge clk);
    wr_valid = w; wr_word = d; rd_strobe = r; rd_lane = l; flush = f;
    @(negedge clk);
    wr_valid = 0; rd_strobe = 0; flush = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 level", fill_level, 0);
    check("R1 lost", lost_flag, 0);
    check("R1 byte", rd_byte, 0);

    // vector table: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][43:42])
        2'd0: cyc(1, VEC[i][39:8], 0, 0, 0);
        2'd1: begin
          cyc(0, 0, 1, VEC[i][41:40], 0);
          check($sformatf("R3/R4 vec %0d byte", i), rd_byte, VEC[i][7:0]);
        end
        default: check($sformatf("R2/R4 vec %0d level", i), fill_level, VEC[i][7:0]);
      endcase
    end

    // R5: empty read leaves state alone
    cyc(0, 0, 1, 2'd2, 0);
    check("R5 byte", rd_byte, 0);
    check("R5 level", fill_level, 0);
    check("R5 lost", lost_flag, 0);

    // R2: fill to full
    for (int i = 0; i < DEPTH; i++) cyc(1, 32'hA5000000 | 32'(i), 0, 0, 0);
    check("R2 full level", fill_level, DEPTH);
    check("R2 lost before drop", lost_flag, 0);

    // R6: drop while full
    cyc(1, 32'hDEADBEEF, 0, 0, 0);
    check("R6 level", fill_level, DEPTH);
    check("R6 lost", lost_flag, 1);

    // R7: read clears; R6 contents unchanged
    cyc(0, 0, 1, 2'd0, 0);
    check("R7 lost cleared", lost_flag, 0);
    check("R6 head byte", rd_byte, 8'h00);
    cyc(0, 0, 1, 2'd3, 0);
    check("R3 lane3", rd_byte, 8'hA5);

    // R8: write plus wrap removal at full
    cyc(1, 32'h12345678, 1, 2'd0, 0);
    check("R8 level", fill_level, DEPTH);
    check("R8 lost", lost_flag, 0);
    check("R4 next head byte", rd_byte, 8'h01);

    // R9: flush overrides a write and cancels a pending wrap
    cyc(0, 0, 1, 2'd3, 0);
    cyc(1, 32'h0, 0, 0, 1);
    check("R9 level", fill_level, 0);
    check("R9 lost", lost_flag, 0);
    cyc(1, 32'h0000_00C3, 0, 0, 0);
    cyc(0, 0, 1, 2'd0, 0);
    check("R9 no wrap after flush byte", rd_byte, 8'hC3);
    check("R9 no wrap after flush level", fill_level, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule